// File: doc/BRIEF.md
# Exception Lifecycle Controller

This block holds the pending and active state of every exception vector of a processor's interrupt controller and moves each vector through its life. A rising edge on an external interrupt line, a software set strobe or a software trigger write makes a vector pending. An acknowledge command from the core moves the chosen vector from pending to active. A completion command retires an active vector and reports whether the return was legal and whether it returns to base level. Choosing which pending vector wins is done by an arbiter outside this block, which feeds back the winner's number on the acknowledge port.

Vectors 0 and 1 are reserved and never pend. Vector 2 is the non-maskable vector with fixed priority -2, and vector 3 is the hard fault vector with fixed priority -1. Vectors 4 to 15 are internal and take their priority from the priority input. Vectors 16 and up belong to the external lines, so line i is vector 16+i. Vectors 3 to 13 are synchronous faults. When one of them is requested but cannot be taken, the block pends the hard fault vector in its place and records a forced-escalation status. If the hard fault cannot be taken either, it raises lockup.

Top module: `exc_lifecycle`

## Requirements
- R1: After reset, every pending and active bit is 0, and cpl_illegal_o, cpl_base_o, hf_forced_o, lockup_o and isr_pend_o are all 0.
- R2: A 0-to-1 transition on irq_lvl_i[i] sets pend_o[16+i] at the next clock edge. Keeping the line high does not set the bit again after it has been cleared.
- R3: set_pend_i[v] sets pend_o[v] and clr_pend_i[v] clears it, at the next edge. When both are asserted for the same vector in the same cycle, the set wins.
- R4: A sw_trig_i strobe pends vector sw_trig_val_i+16, but only if that number is below the vector count. A higher number changes nothing.
- R5: An acknowledge of vector v clears pend_o[v] and sets act_o[v] at the next edge, but only when v is pending and enable_i[v] is 1. Otherwise the acknowledge has no effect.
- R6: A completion of an active vector clears its act_o bit and drives cpl_illegal_o to 0 on the next cycle. A completion of a vector that is not active drives cpl_illegal_o to 1 and changes no state. Both outputs hold until the next completion.
- R7: On completion, cpl_base_o is 1 when at most one vector was active just before the completion, and 0 when two or more were active.
- R8: When an external vector completes while its line is still high, its pending bit is set again at the same edge.
- R9: A set request for a vector in 3..13 escalates when its priority is greater than or equal to exec_prio_i, or when it is disabled. Priorities are compared as signed values, and vector 3 always counts as enabled. An escalated vector is not pended. Vector 3 is pended in its place, and hf_forced_o becomes 1 and stays 1 until reset.
- R10: If escalation is needed while exec_prio_i is -1 or lower, the hard fault vector is not pended and hf_forced_o is not set. Instead lockup_o becomes 1 and stays 1 until reset.
- R11: Set requests for vectors outside 3..13 never escalate, even when the vector is disabled or its priority is not high enough.
- R12: isr_pend_o is 1 exactly when any vector numbered 16 or above is pending.
- R13: Set requests for vectors 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | NUM_EXT | External interrupt line levels; line i maps to vector 16+i |
| set_pend_i | input | NUM_VEC | Per-vector software set-pending strobes |
| clr_pend_i | input | NUM_VEC | Per-vector software clear-pending strobes |
| enable_i | input | NUM_VEC | Per-vector enable |
| prio_i | input | NUM_VEC*PRIO_W | Unsigned priority of vector v in bits [v*PRIO_W +: PRIO_W]; used for vectors 4 and up |
| exec_prio_i | input | PRIO_W+2 | Signed current execution priority; 2**PRIO_W means that no exception is running |
| sw_trig_i | input | 1 | Software trigger write strobe |
| sw_trig_val_i | input | 9 | Software trigger value; selects vector value+16 |
| ack_i | input | 1 | Acknowledge command |
| ack_vec_i | input | VEC_W | Vector to acknowledge |
| cpl_i | input | 1 | Completion command |
| cpl_vec_i | input | VEC_W | Vector to complete |
| pend_o | output | NUM_VEC | Pending bits |
| act_o | output | NUM_VEC | Active bits |
| isr_pend_o | output | 1 | Some external vector is pending |
| cpl_illegal_o | output | 1 | Result of the last completion: the vector was not active |
| cpl_base_o | output | 1 | Result of the last completion: return to base level |
| hf_forced_o | output | 1 | Sticky flag: a fault was escalated to the hard fault vector |
| lockup_o | output | 1 | Sticky flag: an escalation could not be taken |

## Verification
Escalation is checked with a table of single set requests, each made from a fresh reset. The table varies the vector number, its priority, its enable and the execution priority. It separates a vector that pends normally from one escalated for priority (both the equal case and the greater case), from one escalated because it is disabled, and from one that ends in lockup. Vectors just inside and just outside the synchronous range, the hard fault vector itself and the non-maskable vector confirm that only vectors 3..13 escalate. Directed sequences cover the other behaviours. Edge latching is tested with a line held high across a clear. Re-pending is tested by completing with the line high and then low. Completion status is tested with one active vector, two active vectors and no active vector. Acknowledge is tested on a disabled vector and on a vector that is not pending, and the software trigger on a number just past the top vector.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int FIRST_EXT    = 16;  // external line 0 maps here
  localparam int MIN_PEND_VEC = 2;   // vectors below never pend
  localparam int NMI_VEC      = 2;
  localparam int HARD_VEC     = 3;
  localparam int SYNC_END     = 14;  // synchronous range is [HARD_VEC, SYNC_END)
  localparam int TRIG_W       = 9;
endpackage

// File: rtl/exc_edge_detect.sv
module exc_edge_detect #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate import exc_pkg::*; #(
  parameter int NUM_VEC = 24,
  parameter int PRIO_W  = 8,
  localparam int PW     = PRIO_W + 2
) (
  input  logic [NUM_VEC-1:0]        set_i,
  input  logic [NUM_VEC-1:0]        enable_i,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_i,
  input  logic [PW-1:0]             exec_prio_i,
  output logic [NUM_VEC-1:0]        pass_o,
  output logic                      hard_set_o,
  output logic                      lock_o
);
  localparam logic signed [PW-1:0] HARD_PRIO = -PW'(1);

  logic [NUM_VEC-1:0] esc;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v >= HARD_VEC && v < SYNC_END) begin : g_sync
      logic signed [PW-1:0] eff;
      logic                 en_eff;
      if (v == HARD_VEC) begin : g_hard
        assign eff    = HARD_PRIO;
        assign en_eff = 1'b1;
      end else begin : g_cfg
        assign eff    = $signed({2'b00, prio_i[v*PRIO_W +: PRIO_W]});
        assign en_eff = enable_i[v];
      end
      assign esc[v] = set_i[v] && ((eff >= $signed(exec_prio_i)) || !en_eff);
    end else begin : g_async
      assign esc[v] = 1'b0;
    end
  end

  logic any_esc, hard_ok;
  assign any_esc    = |esc;
  assign hard_ok    = $signed(exec_prio_i) > HARD_PRIO;
  assign pass_o     = set_i & ~esc;
  assign hard_set_o = any_esc && hard_ok;
  assign lock_o     = any_esc && !hard_ok;
endmodule

// File: rtl/exc_vec_state.sv
module exc_vec_state import exc_pkg::*; #(
  parameter int NUM_VEC = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  input  logic [NUM_VEC-1:0] act_set_i,
  input  logic [NUM_VEC-1:0] act_clr_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] act_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v < MIN_PEND_VEC) begin : g_rsvd
      assign pend_o[v] = 1'b0;
      assign act_o[v]  = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_o[v] <= 1'b0;
          act_o[v]  <= 1'b0;
        end else begin
          // set beats clear
          if (pend_set_i[v])      pend_o[v] <= 1'b1;
          else if (pend_clr_i[v]) pend_o[v] <= 1'b0;
          if (act_set_i[v])       act_o[v]  <= 1'b1;
          else if (act_clr_i[v])  act_o[v]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/exc_lifecycle.sv
module exc_lifecycle import exc_pkg::*; #(
  parameter int NUM_EXT = 8,
  parameter int PRIO_W  = 8,
  localparam int NUM_VEC = FIRST_EXT + NUM_EXT,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int PW      = PRIO_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_EXT-1:0]        irq_lvl_i,
  input  logic [NUM_VEC-1:0]        set_pend_i,
  input  logic [NUM_VEC-1:0]        clr_pend_i,
  input  logic [NUM_VEC-1:0]        enable_i,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_i,
  input  logic [PW-1:0]             exec_prio_i,
  input  logic                      sw_trig_i,
  input  logic [TRIG_W-1:0]         sw_trig_val_i,
  input  logic                      ack_i,
  input  logic [VEC_W-1:0]          ack_vec_i,
  input  logic                      cpl_i,
  input  logic [VEC_W-1:0]          cpl_vec_i,
  output logic [NUM_VEC-1:0]        pend_o,
  output logic [NUM_VEC-1:0]        act_o,
  output logic                      isr_pend_o,
  output logic                      cpl_illegal_o,
  output logic                      cpl_base_o,
  output logic                      hf_forced_o,
  output logic                      lockup_o
);
  logic [NUM_EXT-1:0] ext_rise;
  logic [NUM_VEC-1:0] sw_pass, trig_mask, ack_mask, cpl_mask, repend_mask;
  logic [NUM_VEC-1:0] pend_set, pend_clr;
  logic               hard_set, lock_req, cpl_ok;
  logic [TRIG_W:0]    trig_num;

  exc_edge_detect #(.N(NUM_EXT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_lvl_i),
    .rise_o (ext_rise)
  );

  exc_escalate #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_esc (
    .set_i       (set_pend_i),
    .enable_i    (enable_i),
    .prio_i      (prio_i),
    .exec_prio_i (exec_prio_i),
    .pass_o      (sw_pass),
    .hard_set_o  (hard_set),
    .lock_o      (lock_req)
  );

  assign trig_num = {1'b0, sw_trig_val_i} + (TRIG_W+1)'(FIRST_EXT);

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      trig_mask[v] = sw_trig_i && (trig_num == (TRIG_W+1)'(v));
      ack_mask[v]  = ack_i && (ack_vec_i == VEC_W'(v)) && pend_o[v] && enable_i[v];
      cpl_mask[v]  = cpl_i && (cpl_vec_i == VEC_W'(v)) && act_o[v];
    end
  end

  assign cpl_ok = |cpl_mask;

  always_comb begin
    repend_mask = '0;
    for (int i = 0; i < NUM_EXT; i++)
      repend_mask[FIRST_EXT+i] = cpl_mask[FIRST_EXT+i] && irq_lvl_i[i];
  end

  always_comb begin
    pend_set = sw_pass | trig_mask | repend_mask
             | {ext_rise, {FIRST_EXT{1'b0}}};
    pend_set[HARD_VEC] = pend_set[HARD_VEC] | hard_set;
    pend_clr = clr_pend_i | ack_mask;
  end

  exc_vec_state #(.NUM_VEC(NUM_VEC)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_set_i (pend_set),
    .pend_clr_i (pend_clr),
    .act_set_i  (ack_mask),
    .act_clr_i  (cpl_mask),
    .pend_o     (pend_o),
    .act_o      (act_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_illegal_o <= 1'b0;
      cpl_base_o    <= 1'b0;
      hf_forced_o   <= 1'b0;
      lockup_o      <= 1'b0;
    end else begin
      if (cpl_i) begin
        cpl_illegal_o <= !cpl_ok;
        cpl_base_o    <= ($countones(act_o) <= 1);  // count before retiring
      end
      if (hard_set) hf_forced_o <= 1'b1;
      if (lock_req) lockup_o    <= 1'b1;
    end
  end

  assign isr_pend_o = |pend_o[NUM_VEC-1:FIRST_EXT];
endmodule

// File: rtl/exc_lifecycle_chk.sv
module exc_lifecycle_chk import exc_pkg::*; #(
  parameter int NUM_EXT = 8,
  parameter int PRIO_W  = 8,
  localparam int NUM_VEC = FIRST_EXT + NUM_EXT,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EXT-1:0] irq_lvl_i,
  input logic [NUM_VEC-1:0] clr_pend_i,
  input logic [NUM_VEC-1:0] enable_i,
  input logic               ack_i,
  input logic [VEC_W-1:0]   ack_vec_i,
  input logic               cpl_i,
  input logic [VEC_W-1:0]   cpl_vec_i,
  input logic [NUM_VEC-1:0] pend_o,
  input logic [NUM_VEC-1:0] act_o,
  input logic               cpl_illegal_o,
  input logic               cpl_base_o,
  input logic               hf_forced_o,
  input logic               lockup_o
);
  logic ack_in, cpl_in;
  assign ack_in = 32'(ack_vec_i) < NUM_VEC;
  assign cpl_in = 32'(cpl_vec_i) < NUM_VEC;

  // R5
  ack_to_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && ack_in && pend_o[ack_vec_i] && enable_i[ack_vec_i]
    |=> act_o[$past(ack_vec_i)]);

  // R6
  cpl_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_i && cpl_in && !act_o[cpl_vec_i] |=> cpl_illegal_o);

  // R6
  cpl_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_i && cpl_in && act_o[cpl_vec_i] && !(ack_i && ack_vec_i == cpl_vec_i)
    |=> !act_o[$past(cpl_vec_i)] && !cpl_illegal_o);

  // R7
  cpl_nested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_i && cpl_in && act_o[cpl_vec_i] && $countones(act_o) > 1
    |=> !cpl_base_o);

  // R9
  forced_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_forced_o |=> hf_forced_o);

  // R10
  lockup_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockup_o |=> lockup_o);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    // R2
    ext_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_lvl_i[i]) && !clr_pend_i[FIRST_EXT+i] |=> pend_o[FIRST_EXT+i]);
  end
endmodule

bind exc_lifecycle exc_lifecycle_chk #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_lvl_i     (irq_lvl_i),
  .clr_pend_i    (clr_pend_i),
  .enable_i      (enable_i),
  .ack_i         (ack_i),
  .ack_vec_i     (ack_vec_i),
  .cpl_i         (cpl_i),
  .cpl_vec_i     (cpl_vec_i),
  .pend_o        (pend_o),
  .act_o         (act_o),
  .cpl_illegal_o (cpl_illegal_o),
  .cpl_base_o    (cpl_base_o),
  .hf_forced_o   (hf_forced_o),
  .lockup_o      (lockup_o)
);

// File: tb/exc_lifecycle_test.sv
module exc_lifecycle_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EXT = 8;
  localparam int NUM_VEC = 24;
  localparam int PRIO_W  = 8;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [NUM_EXT-1:0]        irq_lvl = '0;
  logic [NUM_VEC-1:0]        set_pend = '0, clr_pend = '0, enable = '1;
  logic [NUM_VEC*PRIO_W-1:0] prio = '0;
  logic [9:0]                exec_prio = 10'h100;
  logic                      sw_trig = 1'b0;
  logic [8:0]                sw_trig_val = '0;
  logic                      ack = 1'b0, cpl = 1'b0;
  logic [4:0]                ack_vec = '0, cpl_vec = '0;
  logic [NUM_VEC-1:0]        pend, act;
  logic                      isr_pend, cpl_illegal, cpl_base, hf_forced, lockup;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_lifecycle #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lvl_i(irq_lvl), .set_pend_i(set_pend),
    .clr_pend_i(clr_pend), .enable_i(enable), .prio_i(prio), .exec_prio_i(exec_prio),
    .sw_trig_i(sw_trig), .sw_trig_val_i(sw_trig_val), .ack_i(ack), .ack_vec_i(ack_vec),
    .cpl_i(cpl), .cpl_vec_i(cpl_vec), .pend_o(pend), .act_o(act), .isr_pend_o(isr_pend),
    .cpl_illegal_o(cpl_illegal), .cpl_base_o(cpl_base), .hf_forced_o(hf_forced),
    .lockup_o(lockup)
  );

  typedef struct packed {
    logic [4:0] vec;
    logic [7:0] pr;
    logic       en;
    logic [9:0] xp;
    logic       e_self, e_hard, e_forced, e_lock;
  } esc_row_t;

  localparam int NROWS = 12;
  localparam esc_row_t ROWS [NROWS] = '{
    '{5'd5,  8'h40, 1'b1, 10'h100, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'd5,  8'h40, 1'b1, 10'h040, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd5,  8'h40, 1'b1, 10'h030, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd5,  8'h40, 1'b0, 10'h100, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd13, 8'h10, 1'b1, 10'h020, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'd13, 8'h20, 1'b1, 10'h020, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd14, 8'h20, 1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'd20, 8'h80, 1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'd5,  8'h40, 1'b1, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{5'd3,  8'h00, 1'b1, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5'd3,  8'h00, 1'b1, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{5'd2,  8'h00, 1'b1, 10'h3FE, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] actv, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] actv, input logic [63:0] expv);
    chk(actv === expv, req, actv, expv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_lvl = '0; set_pend = '0; clr_pend = '0; enable = '1; prio = '0;
    exec_prio = 10'h100; sw_trig = 1'b0; ack = 1'b0; cpl = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one command cycle: strobes were set before call; clear them after one edge
  task automatic step();
    @(negedge clk);
    set_pend = '0; clr_pend = '0; sw_trig = 1'b0; ack = 1'b0; cpl = 1'b0;
  endtask

  task automatic do_ack(input int v);
    ack = 1'b1; ack_vec = 5'(v); step();
  endtask

  task automatic do_cpl(input int v);
    cpl = 1'b1; cpl_vec = 5'(v); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [NUM_VEC-1:0] snap;
    do_reset();
    // R1 reset state
    chk_eq("R1 pend", 64'(pend), 0);
    chk_eq("R1 act", 64'(act), 0);
    chk_eq("R1 flags", {isr_pend, cpl_illegal, cpl_base, hf_forced, lockup}, 0);

    // R9 R10 R11 escalation table
    for (int r = 0; r < NROWS; r++) begin
      do_reset();
      prio[ROWS[r].vec*PRIO_W +: PRIO_W] = ROWS[r].pr;
      enable[ROWS[r].vec] = ROWS[r].en;
      exec_prio = ROWS[r].xp;
      set_pend[ROWS[r].vec] = 1'b1;
      step();
      chk_eq($sformatf("R9/R11 row%0d self pend", r), pend[ROWS[r].vec], ROWS[r].e_self);
      chk_eq($sformatf("R9 row%0d hard pend", r), pend[3], ROWS[r].e_hard);
      chk_eq($sformatf("R9 row%0d forced", r), hf_forced, ROWS[r].e_forced);
      chk_eq($sformatf("R10 row%0d lockup", r), lockup, ROWS[r].e_lock);
    end

    // R2 edge latch, R12 summary
    do_reset();
    irq_lvl[2] = 1'b1;
    @(negedge clk);
    chk_eq("R2 rise pends 18", pend[18], 1);
    chk_eq("R12 isr_pend set", isr_pend, 1);
    clr_pend[18] = 1'b1; step();
    @(negedge clk); @(negedge clk);
    chk_eq("R2 held high no repend", pend[18], 0);
    chk_eq("R12 isr_pend clear", isr_pend, 0);
    irq_lvl[2] = 1'b0; @(negedge clk);
    irq_lvl[2] = 1'b1; @(negedge clk);
    chk_eq("R2 second rise", pend[18], 1);

    // R3 set beats clear
    do_reset();
    set_pend[20] = 1'b1; clr_pend[20] = 1'b1; step();
    chk_eq("R3 set wins", pend[20], 1);
    clr_pend[20] = 1'b1; step();
    chk_eq("R3 clear", pend[20], 0);

    // R4 software trigger
    sw_trig = 1'b1; sw_trig_val = 9'd5; step();
    chk_eq("R4 trig 21", 64'(pend), 64'(1) << 21);
    snap = pend;
    sw_trig = 1'b1; sw_trig_val = 9'd8; step();
    chk_eq("R4 trig out of range", 64'(pend), 64'(snap));

    // R13 reserved vectors
    set_pend[0] = 1'b1; set_pend[1] = 1'b1; step();
    chk_eq("R13 reserved", pend[1:0], 0);

    // R5 acknowledge
    do_ack(21);
    chk_eq("R5 ack pend", pend[21], 0);
    chk_eq("R5 ack act", act[21], 1);
    do_ack(22);
    chk_eq("R5 ack not pending", act[22], 0);
    set_pend[19] = 1'b1; step();
    enable[19] = 1'b0;
    do_ack(19);
    chk_eq("R5 ack disabled", {pend[19], act[19]}, 2'b10);
    enable[19] = 1'b1;

    // R6 R7 completion
    do_cpl(21);
    chk_eq("R6 retire", {act[21], cpl_illegal}, 0);
    chk_eq("R7 single active base", cpl_base, 1);
    do_cpl(21);
    chk_eq("R6 illegal", cpl_illegal, 1);
    chk_eq("R6 illegal no change", 64'(act), 0);

    do_reset();
    set_pend[20] = 1'b1; set_pend[21] = 1'b1; step();
    do_ack(20); do_ack(21);
    chk_eq("R5 two active", act[21:20], 2'b11);
    do_cpl(21);
    chk_eq("R7 nested base", {cpl_base, cpl_illegal}, 0);
    do_cpl(20);
    chk_eq("R7 last base", {cpl_base, cpl_illegal}, 2'b10);

    // R8 re-pend while line high
    do_reset();
    irq_lvl[4] = 1'b1; @(negedge clk);
    do_ack(20);
    do_cpl(20);
    chk_eq("R8 repend high", {pend[20], act[20]}, 2'b10);
    irq_lvl[4] = 1'b0;
    do_ack(20);
    do_cpl(20);
    chk_eq("R8 no repend low", {pend[20], act[20]}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule